// File: doc/BRIEF.md
# Carry-Select Hybrid 32-bit Integer ALU

This block is a combinational integer arithmetic and logic unit for a 32-bit datapath. It adds, subtracts, and forms the bitwise AND, OR and XOR of two operands under a 3-bit operation code. It also produces a zero flag and a carry flag. An operand conditioner comes first. It sets up the adder inputs: B is inverted and the carry-in is forced high for subtraction. It also forms the bitwise results, which skip the adder.

The adder is split unevenly. The low 25 bits use carry-lookahead groups: five of 4 bits and a final group of 5 bits, chained group to group. The upper 7 bits are computed twice, once assuming no incoming carry and once assuming one. The carry out of the low section then picks one of the two. This shortens the longest path, because the upper section works in parallel with the low one. The unit sits between register reads and write-back, and the surrounding pipeline registers its outputs.

Top module: `csel_alu`

## Requirements
- R1: With op 000 (add), result equals (a + b) mod 2^32 and carry equals bit 32 of the full sum.
- R2: With op 001 (subtract), result equals (a - b) mod 2^32, and carry is 1 exactly when a >= b as unsigned numbers (no borrow).
- R3: With op 010, result equals a AND b and carry is 0.
- R4: With op 011, result equals a OR b and carry is 0.
- R5: With op 100, result equals a XOR b and carry is 0.
- R6: With op 101, 110 or 111, result is 0 and carry is 0 whatever the operands are.
- R7: zero is 1 exactly when the 32-bit result is all zeros, for every operation code.
- R8: Carries propagate correctly across every boundary between the lookahead groups of the low section (bits 3/4, 7/8, 11/12, 15/16, 19/20, and into the 5-bit group spanning bits 20 to 24).
- R9: A carry leaving bit 24 is reflected in bits 25 to 31 and in the carry flag, for addition and for subtraction alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand (minuend for subtraction) |
| b | input | 32 | Second operand (subtrahend for subtraction) |
| op | input | 3 | Operation code: 000 add, 001 subtract, 010 AND, 011 OR, 100 XOR, others give zero |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry | output | 1 | Adder carry out for add and subtract, 0 otherwise |

## Verification
The hardest case to reach is a carry that crosses the seam between the lookahead section and the duplicated upper section. Only there does the choice between the two precomputed upper sums matter. Random operands almost never make a long run of ones end exactly at bit 24. The stimulus therefore adds directed pairs with a run of ones up to bit 24, or up to a group edge, plus one; the subtraction cases cross the same seam through the inverted subtrahend. Random vectors with operands biased toward all-ones or all-zeros words then repeat those patterns across all operation codes.

// File: rtl/csel_alu_pkg.sv
package csel_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } alu_op_e;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] p, g;
  logic [W:0]   c;

  always_comb begin
    p = a ^ b;
    g = a & b;
    c = '0;
    c[0] = cin;
    for (int i = 1; i <= W; i++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = -1; j < i; j++) begin
        term = (j < 0) ? cin : g[j];
        for (int k = j + 1; k < i; k++) begin
          if (k >= 0) term = term & p[k];
        end
        acc = acc | term;
      end
      c[i] = acc;
    end
    sum  = p ^ c[W-1:0];
    cout = c[W];
  end

  // R8
  always_comb begin
    cla_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("lookahead group sum mismatch");
  end
endmodule

// File: rtl/low_adder.sv
module low_adder #(
  parameter int LOW_W = 25,
  parameter int GRP_W = 4
) (
  input  logic [LOW_W-1:0] a,
  input  logic [LOW_W-1:0] b,
  input  logic             cin,
  output logic [LOW_W-1:0] sum,
  output logic             cout
);
  localparam int NGRP   = LOW_W / GRP_W;
  localparam int LAST_W = LOW_W - (NGRP - 1) * GRP_W;

  logic [NGRP:0] gc;
  assign gc[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int GW = (gi == NGRP - 1) ? LAST_W : GRP_W;
    cla_group #(.W(GW)) u_grp (
      .a   (a[gi*GRP_W +: GW]),
      .b   (b[gi*GRP_W +: GW]),
      .cin (gc[gi]),
      .sum (sum[gi*GRP_W +: GW]),
      .cout(gc[gi+1])
    );
  end

  assign cout = gc[NGRP];

  // R8
  always_comb begin
    low_chain_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{LOW_W{1'b0}}, cin}))
      else $error("low section chain mismatch");
  end
endmodule

// File: rtl/hi_select.sv
module hi_select #(
  parameter int HI_W = 7
) (
  input  logic [HI_W-1:0] a,
  input  logic [HI_W-1:0] b,
  input  logic            sel,
  output logic [HI_W-1:0] sum,
  output logic            cout
);
  logic [HI_W-1:0] s0, s1;
  logic            c0, c1;

  cla_group #(.W(HI_W)) u_c0 (.a(a), .b(b), .cin(1'b0), .sum(s0), .cout(c0));
  cla_group #(.W(HI_W)) u_c1 (.a(a), .b(b), .cin(1'b1), .sum(s1), .cout(c1));

  assign sum  = sel ? s1 : s0;
  assign cout = sel ? c1 : c0;

  // R9
  always_comb begin
    hi_pair_chk: assert ({c1, s1} == ({c0, s0} + {{HI_W{1'b0}}, 1'b1}))
      else $error("upper candidates disagree");
  end
endmodule

// File: rtl/op_modifier.sv
module op_modifier
  import csel_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] am,
  output logic [WIDTH-1:0] bm,
  output logic             cin,
  output logic             is_arith,
  output logic [WIDTH-1:0] logic_res
);
  always_comb begin
    am        = a;
    bm        = b;
    cin       = 1'b0;
    is_arith  = 1'b0;
    logic_res = '0;
    case (op)
      OP_ADD: is_arith = 1'b1;
      OP_SUB: begin
        is_arith = 1'b1;
        bm       = ~b;
        cin      = 1'b1;
      end
      OP_AND: logic_res = a & b;
      OP_OR:  logic_res = a | b;
      OP_XOR: logic_res = a ^ b;
      default: logic_res = '0;
    endcase
  end

  // R2
  always_comb begin
    if (op == OP_SUB) begin
      sub_invert_chk: assert (((bm ^ b) == {WIDTH{1'b1}}) && cin)
        else $error("subtract conditioning wrong");
    end
  end
endmodule

// File: rtl/csel_alu.sv
module csel_alu
  import csel_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LOW_W = 25,
  parameter int GRP_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry
);
  localparam int HI_W = WIDTH - LOW_W;

  logic [WIDTH-1:0] am, bm, logic_res, sum;
  logic             cin, is_arith, low_c, hi_c;

  op_modifier #(.WIDTH(WIDTH)) u_mod (
    .a(a), .b(b), .op(op), .am(am), .bm(bm), .cin(cin),
    .is_arith(is_arith), .logic_res(logic_res)
  );

  low_adder #(.LOW_W(LOW_W), .GRP_W(GRP_W)) u_low (
    .a(am[LOW_W-1:0]), .b(bm[LOW_W-1:0]), .cin(cin),
    .sum(sum[LOW_W-1:0]), .cout(low_c)
  );

  hi_select #(.HI_W(HI_W)) u_hi (
    .a(am[WIDTH-1:LOW_W]), .b(bm[WIDTH-1:LOW_W]), .sel(low_c),
    .sum(sum[WIDTH-1:LOW_W]), .cout(hi_c)
  );

  assign result = is_arith ? sum : logic_res;
  assign carry  = is_arith & hi_c;
  assign zero   = ~|result;

  // R1
  always_comb begin
    if (op == OP_ADD) begin
      add_sum_chk: assert ({carry, result} == ({1'b0, a} + {1'b0, b}))
        else $error("add result wrong");
    end
  end

  // R3
  always_comb begin
    if (op >= 3'b010) begin
      logic_carry_chk: assert (!carry) else $error("carry set for non-arith op");
    end
  end

  // R6
  always_comb begin
    if (op > 3'b100) begin
      bad_op_chk: assert (zero && result == '0) else $error("unused op not zero");
    end
  end
endmodule

// File: tb/sim_csel_alu.sv
`timescale 1ns/1ps
module sim_csel_alu;
  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic [31:0] result;
  logic        zero, carry;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  csel_alu u0 (.a(a), .b(b), .op(op), .result(result), .zero(zero), .carry(carry));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(string req, logic [33:0] got, logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h got {z,c,r}=%h exp=%h", req, op, a, b, got, exp);
    end
  endtask

  task automatic run(string req, logic [31:0] ta, logic [31:0] tb_, logic [2:0] top);
    longint unsigned ua, ub, full;
    logic [31:0] er;
    logic        ec;
    @(posedge clk);
    a = ta; b = tb_; op = top;
    ua = longint'(ta); ub = longint'(tb_);
    ec = 1'b0;
    case (top)
      3'd0: begin full = ua + ub; er = full[31:0]; ec = full[32]; end
      3'd1: begin er = ta - tb_; ec = (ua >= ub); end
      3'd2: er = ta & tb_;
      3'd3: er = ta | tb_;
      3'd4: er = ta ^ tb_;
      default: er = 32'd0;
    endcase
    @(negedge clk);
    check(req, {zero, carry, result}, {(er == 32'd0), ec, er});
    check("R7", {33'd0, zero}, {33'd0, (er == 32'd0)});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'hFFFF_FFFF;
      1: return 32'h0000_0000;
      2: return 32'h01FF_FFFF;
      3: return (32'h1 << $urandom_range(0, 31));
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    run("R1", 32'd7, 32'd9, 3'd0);
    run("R1", 32'hFFFF_FFFF, 32'd1, 3'd0);
    run("R1", 32'h8000_0000, 32'h8000_0000, 3'd0);
    run("R2", 32'd5, 32'd3, 3'd1);
    run("R2", 32'd3, 32'd5, 3'd1);
    run("R2", 32'h1234_5678, 32'h1234_5678, 3'd1);
    run("R3", 32'hF0F0_1234, 32'hFF00_FFFF, 3'd2);
    run("R4", 32'hF0F0_1234, 32'h0F00_0001, 3'd3);
    run("R5", 32'hAAAA_5555, 32'hAAAA_5555, 3'd4);
    run("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4);
    run("R6", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd5);
    run("R6", 32'h1234_5678, 32'h0000_0001, 3'd6);
    run("R6", 32'hDEAD_BEEF, 32'h8000_0000, 3'd7);
    for (int k = 0; k < 6; k++) begin
      run("R8", (32'h1 << (4 * k + 4)) - 32'h1, 32'd1, 3'd0);
      run("R8", (32'h1 << (4 * k + 4)), 32'd1, 3'd1);
    end
    run("R9", 32'h01FF_FFFF, 32'd1, 3'd0);
    run("R9", 32'hFFFF_FFFF, 32'h0100_0001, 3'd0);
    run("R9", 32'h0200_0000, 32'd1, 3'd1);
    run("R9", 32'hFE00_0000, 32'h0200_0000, 3'd0);
    run("R9", 32'h0000_0000, 32'h0200_0000, 3'd1);
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 7));
      case (rop)
        3'd0: run("R1", pick(), pick(), rop);
        3'd1: run("R2", pick(), pick(), rop);
        3'd2: run("R3", pick(), pick(), rop);
        3'd3: run("R4", pick(), pick(), rop);
        3'd4: run("R5", pick(), pick(), rop);
        default: run("R6", pick(), pick(), rop);
      endcase
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule